// File: doc/BRIEF.md
# Subranging Converter Correction Sequencer

This block is the digital back end of a four-step subranging analog-to-digital converter. An active-high start pulse begins a conversion. The block then steps through four internal phases and takes one partial code from each flash stage in turn. The stages are a 3-bit first flash, a 3-bit second flash, a 4-bit coarse back-end flash and a 4-bit fine back-end flash.

The partial codes overlap. The second flash shares one bit with the first stage, and the coarse flash shares one bit with the second stage. This spare range absorbs comparator errors in the earlier stage. The block removes the overlap by weighted addition, subtracting half an upstream LSB at each overlapping seam and clamping the sum to the 12-bit range.

The analog front end reports over-range and under-range flags. Either flag raises a range-error output and forces the output word to all ones or all zeros. A ready strobe falls while a conversion runs. It rises in the same cycle in which the new word and range error appear.

Top module: `subrange_corrector`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `ready` is 1, `word` is 0 and `range_err` is 0.
- R2: A conversion starts when `encode` is sampled high at a clock edge after being sampled low at the previous edge. `ready` goes low after that edge. If `encode` is held high through reset, no conversion starts when reset releases.
- R3: After the start edge, `code_a`, `code_b`, `code_c` and `code_d` are sampled on the 1st, 2nd, 3rd and 4th following clock edges. `over_in` and `under_in` are sampled together with `code_d`. Values on those inputs at any other edge have no effect. `ready` stays low for exactly four cycles.
- R4: With no range flag, `word` = a*512 + b*128 + c*16 + d - 320, where a, b, c and d are the sampled codes. The first code carries weight bit 9, the second weight bit 7, the coarse code weight bit 4 and the fine code weight bit 0. The constant 320 is 256 (half a first-stage LSB) plus 64 (half a second-stage LSB).
- R5: A corrected sum below 0 gives `word` = 0. A sum above 4095 gives `word` = 4095. Clamping alone leaves `range_err` at 0.
- R6: If `over_in` is 1 at the final sampling edge, `word` = 4095 and `range_err` = 1. This holds even when `under_in` is also 1.
- R7: If `under_in` is 1 and `over_in` is 0 at the final sampling edge, `word` = 0 and `range_err` = 1.
- R8: A rising `encode` during a conversion is ignored: that conversion yields exactly one result and no second conversion follows. A level held high after the start edge does not restart a conversion.
- R9: `word` and `range_err` change only in the cycle in which `ready` rises. They hold their values while `ready` is low and between conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| encode | input | 1 | Start request, rising edge starts a conversion |
| code_a | input | 3 | First flash stage code |
| code_b | input | 3 | Second flash stage code (one bit overlap) |
| code_c | input | 4 | Coarse back-end flash code (one bit overlap) |
| code_d | input | 4 | Fine back-end flash code |
| over_in | input | 1 | Input above range, sampled with the fine code |
| under_in | input | 1 | Input below range, sampled with the fine code |
| ready | output | 1 | High when idle with a valid word, low during conversion |
| word | output | 12 | Corrected, clamped conversion result |
| range_err | output | 1 | Set when the last conversion was out of range |

## Verification
The hardest conditions to reach from the ports are those where a stage code is taken at the wrong edge, or where a start edge lands during a conversion. When one of these goes wrong, the output word is still a plausible number. To expose such faults, the stimulus holds each stage input at its bitwise complement on every edge except the one on which it must be sampled. Some conversions also carry a fresh start pulse mid-conversion, and others keep `encode` high long after the start edge. The scoreboard expects exactly one result per requested conversion, so any extra or missing result is reported.

// File: rtl/subrange_corrector.sv
module subrange_corrector #(
  parameter int W1 = 3,
  parameter int W2 = 3,
  parameter int W3 = 4,
  parameter int W4 = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           encode,
  input  logic [W1-1:0]                  code_a,
  input  logic [W2-1:0]                  code_b,
  input  logic [W3-1:0]                  code_c,
  input  logic [W4-1:0]                  code_d,
  input  logic                           over_in,
  input  logic                           under_in,
  output logic                           ready,
  output logic [W1+W2+W3+W4-3:0]         word,
  output logic                           range_err
);

  localparam int OUT_W = W1 + W2 + W3 + W4 - 2;
  localparam int SUM_W = OUT_W + 2;
  localparam int P3    = W4;
  localparam int P2    = P3 + W3 - 1;
  localparam int P1    = P2 + W2 - 1;
  localparam logic [SUM_W-1:0] OFS = SUM_W'((1 << (P1 - 1)) + (1 << (P2 - 1)));

  typedef enum logic [2:0] {IDLE, ST1, ST2, ST3, ST4} phase_t;

  phase_t            phase;
  logic              enc_q;
  logic [W1-1:0]     a_q;
  logic [W2-1:0]     b_q;
  logic [W3-1:0]     c_q;
  logic [SUM_W-1:0]  sum;
  logic [OUT_W-1:0]  clamped;
  logic [OUT_W-1:0]  final_word;

  wire start_edge = encode && !enc_q;

  assign sum = (SUM_W'(a_q) << P1) + (SUM_W'(b_q) << P2) + (SUM_W'(c_q) << P3)
             + SUM_W'(code_d) - OFS;

  always_comb begin
    if (sum[SUM_W-1])
      clamped = '0;
    else if (sum[SUM_W-2:OUT_W] != '0)
      clamped = '1;
    else
      clamped = sum[OUT_W-1:0];
  end

  assign final_word = over_in ? '1 : (under_in ? '0 : clamped);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= IDLE;
      enc_q     <= 1'b1;
      ready     <= 1'b1;
      word      <= '0;
      range_err <= 1'b0;
      a_q       <= '0;
      b_q       <= '0;
      c_q       <= '0;
    end else begin
      enc_q <= encode;
      case (phase)
        IDLE: if (start_edge) begin
          phase <= ST1;
          ready <= 1'b0;
        end
        ST1: begin
          a_q   <= code_a;
          phase <= ST2;
        end
        ST2: begin
          b_q   <= code_b;
          phase <= ST3;
        end
        ST3: begin
          c_q   <= code_c;
          phase <= ST4;
        end
        ST4: begin
          word      <= final_word;
          range_err <= over_in | under_in;
          ready     <= 1'b1;
          phase     <= IDLE;
        end
        default: phase <= IDLE;
      endcase
    end
  end

  p_busy_low_r2: assert property (@(posedge clk) disable iff (rst)
    (phase != IDLE) |-> !ready);

  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == IDLE && encode && !enc_q) |=> (!ready && phase == ST1));

  p_finish_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == ST4) |=> ready);

  p_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (phase == ST2 && encode && !enc_q) |=> (phase == ST3));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (phase != ST4) |=> ($stable(word) && $stable(range_err)));

  p_over_r6: assert property (@(posedge clk) disable iff (rst)
    (phase == ST4 && over_in) |=> (word == '1 && range_err));

  p_under_r7: assert property (@(posedge clk) disable iff (rst)
    (phase == ST4 && !over_in && under_in) |=> (word == '0 && range_err));

  p_clamp_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == ST4 && !over_in && !under_in) |=> !range_err);

endmodule

// File: tb/subrange_corrector_tb.sv
module subrange_corrector_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic encode = 1'b0;
  logic [2:0] code_a = '0, code_b = '0;
  logic [3:0] code_c = '0, code_d = '0;
  logic over_in = 1'b0, under_in = 1'b0;
  logic ready, range_err;
  logic [11:0] word;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [12:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  subrange_corrector dut_i (
    .clk(clk), .rst(rst), .encode(encode),
    .code_a(code_a), .code_b(code_b), .code_c(code_c), .code_d(code_d),
    .over_in(over_in), .under_in(under_in),
    .ready(ready), .word(word), .range_err(range_err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [12:0] model(input int a, b, c, d, input bit ov, un);
    int s;
    s = a * 512 + b * 128 + c * 16 + d - 320;
    if (ov) return {1'b1, 12'hFFF};
    if (un) return {1'b1, 12'h000};
    if (s < 0) s = 0;
    if (s > 4095) s = 4095;
    return {1'b0, 12'(s)};
  endfunction

  // mode 0: single pulse, 1: extra pulse mid-conversion, 2: encode held high
  task automatic convert(input int a, b, c, d, input bit ov, un, input int mode, input string tag);
    exp_q.push_back(model(a, b, c, d, ov, un));
    tag_q.push_back(tag);
    @(negedge clk);
    encode = 1'b1;
    code_a = ~3'(a); code_b = ~3'(b); code_c = ~4'(c); code_d = ~4'(d);
    over_in = ~ov; under_in = ~un;
    @(negedge clk);
    if (mode != 2) encode = 1'b0;
    code_a = 3'(a);
    @(negedge clk);
    if (mode == 1) encode = 1'b1;
    code_a = ~3'(a); code_b = 3'(b);
    @(negedge clk);
    if (mode == 1) encode = 1'b0;
    code_b = ~3'(b); code_c = 4'(c);
    @(negedge clk);
    code_c = ~4'(c); code_d = 4'(d); over_in = ov; under_in = un;
    @(negedge clk);
    code_d = ~4'(d); over_in = 1'b0; under_in = 1'b0;
    repeat (2) @(negedge clk);
    encode = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    bit prev = 1'b1;
    int lowcnt = 0;
    logic [11:0] held_w = '0;
    logic held_o = 1'b0;
    logic [12:0] e;
    string t;
    forever begin
      @(negedge clk);
      if (rst) begin
        prev = 1'b1;
        held_w = 12'h000;
        held_o = 1'b0;
        continue;
      end
      if (!ready) begin
        if (prev) lowcnt = 0;
        lowcnt++;
        chk(word == held_w && range_err == held_o, "R9 hold while busy", int'(word), int'(held_w));
      end else if (!prev) begin
        chk(lowcnt == 4, "R3 busy length", lowcnt, 4);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected result", int'(word), -1);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(word == e[11:0], {t, " word"}, int'(word), int'(e[11:0]));
          chk(range_err == e[12], {t, " range_err"}, int'(range_err), int'(e[12]));
        end
        held_w = word;
        held_o = range_err;
      end else begin
        chk(word == held_w && range_err == held_o, "R9 hold while idle", int'(word), int'(held_w));
      end
      prev = ready;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    encode = 1'b1;
    repeat (4) @(negedge clk);
    chk(ready == 1'b1 && word == 12'h000 && range_err == 1'b0, "R1 reset state", int'(word), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ready == 1'b1 && word == 12'h000 && range_err == 1'b0, "R1 after release", int'(ready), 1);
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R2 no start from level held through reset", int'(ready), 1);
    encode = 1'b0;
    repeat (2) @(negedge clk);

    convert(3, 4, 8, 5, 0, 0, 0, "R4 mid");
    convert(0, 4, 4, 0, 0, 0, 0, "R4 zero point");
    convert(7, 0, 0, 0, 0, 0, 0, "R4 negative overlap");
    for (int i = 0; i < 24; i++)
      convert(i % 8, (i * 3) % 8, (i * 5) % 16, (i * 7) % 16, 0, 0, 0, "R4 sweep");
    convert(0, 0, 0, 0, 0, 0, 0, "R5 clamp low");
    convert(7, 7, 15, 15, 0, 0, 0, "R5 clamp high");
    convert(2, 3, 1, 9, 1, 0, 0, "R6 over");
    convert(2, 3, 1, 9, 1, 1, 0, "R6 over priority");
    convert(6, 5, 14, 2, 0, 1, 0, "R7 under");
    convert(4, 1, 7, 3, 0, 0, 1, "R8 retrigger ignored");
    convert(1, 6, 9, 12, 0, 0, 2, "R8 held level");
    convert(5, 2, 3, 7, 0, 0, 1, "R8 retrigger second");

    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all results delivered", exp_q.size(), 0);
    chk(ready == 1'b1, "R8 idle at end", int'(ready), 1);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule